// File: doc/BRIEF.md
# Reciprocal Dual-Counter Measurement Engine

This block measures an unknown periodic signal against a reference timebase by running two counters over one shared gate. One counter collects whole input cycles. The other collects reference ticks, which arrive as a clock-enable in the system clock domain. The gate opens and closes only on rising edges of the conditioned input. As a result, the input-cycle count is always an exact integer number of periods, and the only quantisation left is the ±1 tick on the reference side.

A measurement starts with a one-cycle `arm` pulse. The gate opens on the first rising edge of the input after arming. It closes on the first rising edge at which at least `min_gate` reference ticks have been collected. The block then pulses `done` and presents both counts.

It also raises a flag that recommends period-style reporting when the input is slower than the square root of the reference rate. Otherwise it recommends frequency-style reporting. The downstream consumer forms frequency as cycles × f_ref / ticks, or elapsed time as ticks / f_ref. That division is not part of this block.

If the input goes quiet for too long, the measurement ends with zero counts.

Top module: `recip_meas_engine`

## Requirements
- R1: After reset, `done` is 0, `cycles_out` and `ticks_out` are 0, and `period_pref` is 0.
- R2: Input edges seen while no measurement is armed have no effect: `done` stays 0 and the outputs keep their values. An `arm` pulse seen when idle starts a measurement, and the gate opens on the first rising edge of `sig_in` after that pulse.
- R3: `cycles_out` equals the number of rising edges of `sig_in` after the opening edge, up to and including the closing edge. This is the number of whole input periods inside the gate.
- R4: `ticks_out` equals the number of cycles with `ref_tick` high strictly after the opening-edge cycle, up to and including the closing-edge cycle.
- R5: The gate closes on the first rising edge at which the tick total, including that cycle's tick, is greater than or equal to `min_gate`. Equality closes the gate, and a value of 0 closes it on the very next edge.
- R6: `done` is high for exactly one cycle, the cycle after the closing edge is sampled. `cycles_out`, `ticks_out` and `period_pref` change only together with a `done` pulse and are held in between.
- R7: `period_pref` is 1 exactly when `cycles_out`² < `ticks_out`. With a gate close to one second, this means the input frequency is below √f_ref.
- R8: If `TMO_TICKS` reference ticks pass without a rising edge of `sig_in`, either while waiting for the opening edge or while the gate is open, the measurement ends. `done` pulses with `cycles_out` = 0, `ticks_out` = 0 and `period_pref` = 0.
- R9: An `arm` pulse received while a measurement is in progress is ignored, and the result is the same as without it.
- R10: Cycles with `ref_tick` low add nothing to the tick total or to the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Conditioned input signal, already synchronous to `clk` |
| ref_tick | input | 1 | Reference timebase enable, one pulse per reference period |
| arm | input | 1 | Start request, one cycle wide |
| min_gate | input | CNT_W | Minimum gate length in reference ticks |
| cycles_out | output | CNT_W | Whole input cycles inside the last gate |
| ticks_out | output | CNT_W | Reference ticks inside the last gate |
| period_pref | output | 1 | 1 = period reporting recommended, 0 = frequency reporting |
| done | output | 1 | One-cycle pulse when new results are presented |

## Verification
The engine is driven with square waves of several periods, both with the tick present on every cycle and with the tick present on every other cycle. The first case makes the tick count equal the elapsed cycles. The second separates tick gating from cycle counting. Minimum gate settings that fall just below, exactly on and just above a multiple of the input period show whether closure uses ≥ and a tick total that includes the current cycle. Mid-gate arms, edges before arming, a flat input and an input that stops after the gate has opened separate the ignore rules from the timeout paths. The recommended-mode flag is exercised on both sides of the cycles² < ticks boundary.

// File: rtl/rme_pkg.sv
package rme_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_GATE = 2'd2
    } phase_e;
endpackage

// File: rtl/rme_edge.sv
module rme_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
        rise   = sig & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/rme_counter.sv
module rme_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    logic [W-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (clr)      value_d = '0;
        else if (inc) value_d = value_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value_q <= '0;
        else        value_q <= value_d;
    end

    assign value = value_q;
endmodule

// File: rtl/recip_meas_engine.sv
module recip_meas_engine #(
    parameter int CNT_W     = 32,
    parameter int TMO_TICKS = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             ref_tick,
    input  logic             arm,
    input  logic [CNT_W-1:0] min_gate,
    output logic [CNT_W-1:0] cycles_out,
    output logic [CNT_W-1:0] ticks_out,
    output logic             period_pref,
    output logic             done
);
    import rme_pkg::*;

    localparam int TMO_W = $clog2(TMO_TICKS + 1);
    localparam int SQ_W  = 2 * CNT_W;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] tck;
        logic             pref;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;

    logic             rise;
    logic [CNT_W-1:0] cnt_a, cnt_b;
    logic [TMO_W-1:0] cnt_t;
    logic             a_clr, a_inc, b_clr, b_inc, t_clr, t_inc;
    logic [CNT_W:0]   b_next;
    logic [CNT_W-1:0] a_next;
    logic [TMO_W:0]   t_next;
    logic [SQ_W-1:0]  a_sq;
    logic             opening, closing, expired, active;

    rme_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (sig_in),
        .rise (rise)
    );

    rme_counter #(.W(CNT_W)) u_cnt_cycles (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (a_clr),
        .inc  (a_inc),
        .value(cnt_a)
    );

    rme_counter #(.W(CNT_W)) u_cnt_ticks (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (b_clr),
        .inc  (b_inc),
        .value(cnt_b)
    );

    rme_counter #(.W(TMO_W)) u_cnt_quiet (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (t_clr),
        .inc  (t_inc),
        .value(cnt_t)
    );

    always_comb begin
        active  = (r_q.ph != PH_IDLE);
        b_next  = {1'b0, cnt_b} + (CNT_W+1)'(ref_tick);
        a_next  = cnt_a + CNT_W'(1);
        t_next  = {1'b0, cnt_t} + (TMO_W+1)'(ref_tick);
        a_sq    = SQ_W'(a_next) * SQ_W'(a_next);
        opening = (r_q.ph == PH_WAIT) && rise;
        closing = (r_q.ph == PH_GATE) && rise && (b_next >= {1'b0, min_gate});
        expired = active && !rise && (t_next >= (TMO_W+1)'(TMO_TICKS));

        a_clr = opening;
        a_inc = (r_q.ph == PH_GATE) && rise;
        b_clr = opening;
        b_inc = (r_q.ph == PH_GATE) && ref_tick;
        t_clr = ((r_q.ph == PH_IDLE) && arm) || rise;
        t_inc = active && ref_tick;

        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: if (arm) r_d.ph = PH_WAIT;
            PH_WAIT: if (opening) r_d.ph = PH_GATE;
            PH_GATE: begin
                if (closing) begin
                    r_d.ph   = PH_IDLE;
                    r_d.cyc  = a_next;
                    r_d.tck  = b_next[CNT_W-1:0];
                    r_d.pref = (a_sq < SQ_W'(b_next));
                    r_d.done = 1'b1;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
        if (expired) begin
            r_d.ph   = PH_IDLE;
            r_d.cyc  = '0;
            r_d.tck  = '0;
            r_d.pref = 1'b0;
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph   <= PH_IDLE;
            r_q.cyc  <= '0;
            r_q.tck  <= '0;
            r_q.pref <= 1'b0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cycles_out  = r_q.cyc;
    assign ticks_out   = r_q.tck;
    assign period_pref = r_q.pref;
    assign done        = r_q.done;

    // R6
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    results_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cycles_out) && $stable(ticks_out) && $stable(period_pref)));

    // R8
    timeout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cycles_out == '0) |-> (ticks_out == '0 && !period_pref));

    // R5
    min_gate_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cycles_out != '0) |-> (ticks_out >= $past(min_gate)));

    // R9
    arm_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_GATE && !closing && !expired) |=> (r_q.ph == PH_GATE));
endmodule

// File: tb/recip_meas_engine_tb.sv
module recip_meas_engine_tb;
    localparam int CW  = 24;
    localparam int TMO = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sig_in = 1'b0;
    logic          ref_tick = 1'b0;
    logic          arm = 1'b0;
    logic [CW-1:0] min_gate = '0;
    logic [CW-1:0] cycles_out, ticks_out;
    logic          period_pref, done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    recip_meas_engine #(.CNT_W(CW), .TMO_TICKS(TMO)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_in     (sig_in),
        .ref_tick   (ref_tick),
        .arm        (arm),
        .min_gate   (min_gate),
        .cycles_out (cycles_out),
        .ticks_out  (ticks_out),
        .period_pref(period_pref),
        .done       (done)
    );

    // Behavioural reference: phase 0 idle, 1 waiting, 2 gate open
    int m_phase = 0, m_edges = 0, m_ticks = 0, m_quiet = 0;
    bit m_prev = 0;
    longint m_a = 0, m_b = 0;
    bit m_pref = 0, m_done = 0;

    always @(posedge clk) begin
        bit r;
        if (!rst_n) begin
            m_phase = 0; m_prev = 0; m_a = 0; m_b = 0; m_pref = 0; m_done = 0;
        end else begin
            r = sig_in && !m_prev;
            m_prev = sig_in;
            m_done = 0;
            if (m_phase == 0) begin
                if (arm) begin m_phase = 1; m_quiet = 0; end
            end else if (m_phase == 1) begin
                if (r) begin
                    m_phase = 2; m_edges = 0; m_ticks = 0; m_quiet = 0;
                end else begin
                    m_quiet += int'(ref_tick);
                    if (m_quiet >= TMO) begin
                        m_phase = 0; m_a = 0; m_b = 0; m_pref = 0; m_done = 1;
                    end
                end
            end else begin
                m_ticks += int'(ref_tick);
                if (r) begin
                    m_edges++; m_quiet = 0;
                    if (m_ticks >= int'(min_gate)) begin
                        m_phase = 0; m_a = m_edges; m_b = m_ticks;
                        m_pref = (m_a * m_a) < m_b; m_done = 1;
                    end
                end else begin
                    m_quiet += int'(ref_tick);
                    if (m_quiet >= TMO) begin
                        m_phase = 0; m_a = 0; m_b = 0; m_pref = 0; m_done = 1;
                    end
                end
            end
        end
    end

    // Cycle-by-cycle comparison against the reference (R3 R4 R6 R7 R8 R10)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_chk++;
            if (done !== m_done || cycles_out !== CW'(m_a) || ticks_out !== CW'(m_b)
                || period_pref !== m_pref) begin
                n_bad++;
                $display("FAIL R3/R4/R6/R7/R8/R10 per-cycle: got done=%0b a=%0d b=%0d p=%0b exp done=%0b a=%0d b=%0d p=%0b",
                         done, cycles_out, ticks_out, period_pref, m_done, m_a, m_b, m_pref);
            end
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    int got_a, got_b, got_p, got_seen;

    // Arms at c=0, drives a square wave of period per (0 = flat low),
    // ticks every tdiv cycles, wave stops at stop_c, optional extra arm.
    task automatic run(input int per, input int mg, input int tdiv,
                       input int stop_c, input int extra_arm);
        got_seen = 0;
        min_gate = CW'(mg);
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (done) begin
                got_seen = 1; got_a = int'(cycles_out);
                got_b = int'(ticks_out); got_p = int'(period_pref);
                break;
            end
            arm      = (c == 0) || (c == extra_arm);
            sig_in   = (per > 0) && (c < stop_c) && ((c % per) >= per / 2);
            ref_tick = (tdiv <= 1) ? 1'b1 : ((c % tdiv) == 0);
        end
        @(negedge clk);
        arm = 0; sig_in = 0; ref_tick = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_res(input string tag, input int a, input int b, input int p);
        check({tag, " done seen"}, got_seen, 1);
        check({tag, " cycles"}, got_a, a);
        check({tag, " ticks"}, got_b, b);
        check({tag, " pref"}, got_p, p);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done", done, 0);
        check("R1 cycles", cycles_out, 0);
        check("R1 ticks", ticks_out, 0);
        check("R1 pref", period_pref, 0);
        rst_n = 1'b1;

        // R2: edges without arming do nothing
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            check("R2 idle done", done, 0);
            sig_in = (c % 6) >= 3;
            ref_tick = 1'b1;
        end
        @(negedge clk); sig_in = 0;
        check("R2 idle cycles", cycles_out, 0);
        repeat (3) @(negedge clk);

        run(10, 35, 1, 100000, -1);
        expect_res("R3 R4 R7 p10 mg35", 4, 40, 1);
        // R6: outputs held after done
        repeat (5) @(negedge clk);
        check("R6 held cycles", cycles_out, 4);
        check("R6 held ticks", ticks_out, 40);
        check("R6 done low", done, 0);

        run(10, 40, 1, 100000, -1);
        expect_res("R5 equal", 4, 40, 1);
        run(10, 41, 1, 100000, -1);
        expect_res("R5 above", 5, 50, 1);
        run(4, 30, 1, 100000, -1);
        expect_res("R7 freq side", 8, 32, 0);
        run(6, 0, 1, 100000, -1);
        expect_res("R5 zero gate", 1, 6, 1);
        run(10, 20, 2, 100000, -1);
        expect_res("R10 half ticks", 4, 20, 1);
        run(0, 10, 1, 100000, -1);
        expect_res("R8 flat", 0, 0, 0);
        run(10, 1000, 1, 30, -1);
        expect_res("R8 stalled gate", 0, 0, 0);
        run(10, 35, 1, 100000, 20);
        expect_res("R9 arm busy", 4, 40, 1);

        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule